// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Controller

This block sits between the status pins of one removable card socket and the host interrupt fabric. It watches two card-detect lines, two battery-voltage-detect lines, ready/busy, write-protect and wait, plus an access-timeout pulse and the card's own I/O interrupt request. Any edge on a watched line latches a sticky change flag. Software clears these flags by writing ones to them. Each flag has its own enable. The enabled pending flags combine into one status-change interrupt. That interrupt, and the card I/O interrupt, can each be steered to either of two active-low host interrupt lines.

Software reaches the block through a 16-bit register port with three words: control, diagnostic and status. The diagnostic word can replace the pin levels with register bits, which allows interrupt paths to be exercised without a card. The status word holds the change flags in its upper byte and the live line levels in its lower byte. The meaning of bit 15 depends on the socket mode: it reads zero in memory-only mode and shows the card I/O interrupt in memory-plus-I/O mode.

Top module: `card_stat_irq`

## Requirements
- R1: Status bits 13..8 are sticky change flags for card detect, battery detect 2, battery detect 1, ready, write protect and access timeout, in that order from bit 13 down. A flag sets on any edge of its synchronized (or overridden) level, or on a high `acc_timeout` cycle for bit 8. Once set, a flag holds until it is cleared.
- R2: The card-detect flag (bit 13) sets on an edge of either card-detect line.
- R3: A write to the status word (`reg_sel`=2) clears each flag whose bit in `reg_wdata[13:8]` is one. Flags written with zero keep their value.
- R4: If a flag is set by hardware in the same cycle that software clears it, the flag ends up set.
- R5: Control bits 11..6 enable the six change flags (card detect at bit 11 down to timeout at bit 6). Status bit 14 is one exactly when at least one enabled flag is pending.
- R6: Control bit 12 routes the status-change interrupt: 0 drives `host_irq_n[0]` low and 1 drives `host_irq_n[1]` low, while status bit 14 is set. A line with nothing routed, enabled and pending stays high.
- R7: The card I/O interrupt drives a host line low only when all of the following hold: the mode bit (control bit 0) is 1, the I/O enable (control bit 4) is 1, and the synchronized `card_irq` is high. Control bit 3 selects the line.
- R8: With control bit 0 at 0, status bit 15 reads zero. With control bit 0 at 1, status bit 15 equals the synchronized `card_irq` level, independent of the I/O enable.
- R9: Status bits 7..0 show the live levels of card detect 2, card detect 1, battery detect 2, battery detect 1, ready, write protect, wait and power-good, from bit 7 down. The layout is the same in both modes; in I/O mode, bits 5..2 carry the speaker, status-change, request and 16-bit-I/O signals on the same pins.
- R10: When diagnostic bit 8 is one, diagnostic bits 14..9 replace the card detect 1, battery detect 2, battery detect 1, ready, write protect and wait pin levels. Both the live view and the change detection use the replaced levels, and edges on the replaced pins have no effect.
- R11: `reg_sel` selects the word: 0 for control, 1 for diagnostic, 2 for status, and 3 reads zero. Unused control and diagnostic bits read zero, and after reset every register bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_pin | input | 2 | Card detect lines, [1]=detect 2, [0]=detect 1 |
| bvd_pin | input | 2 | Battery detect lines, [1]=detect 2, [0]=detect 1 |
| rdy_pin | input | 1 | Ready/busy line |
| wp_pin | input | 1 | Write-protect line |
| wait_pin | input | 1 | Wait line |
| pwr_good | input | 1 | Socket power-on indication |
| card_irq | input | 1 | Card I/O interrupt request level |
| acc_timeout | input | 1 | Synchronous access-timeout pulse |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| host_irq_n | output | 2 | Active-low host interrupt lines |

## Verification
A wrong internal state shows up at the ports in one of three ways. A flag that is lost or spuriously held appears in the upper status byte and on `host_irq_n` three clock edges after the pin edge that should set it, or one edge after the write that should clear it. A broken override or synchronizer shows up in the live low byte two edges after the input change. Routing and mode faults are combinational from the control word, so they are visible in the cycle after the control write.

// File: rtl/card_stat_pkg.sv
`timescale 1ns/1ps
package card_stat_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned NUM_CHG = 6;   // cd, bvd2, bvd1, rdy, wp, timeout
   localparam int unsigned NUM_RAW = 9;   // synchronized pin vector width
   localparam int unsigned CHG_LSB = 8;   // status bit of lowest change flag
   localparam int unsigned EN_LSB  = 6;   // control bit of lowest enable
   localparam int unsigned DG_LSB  = 9;   // diag bit of lowest override value
   localparam int unsigned NUM_DG  = 6;   // cd1, bvd2, bvd1, rdy, wp, wait

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DIAG = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/card_sync.sv
`timescale 1ns/1ps
module card_sync #(
   parameter int unsigned W      = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("card_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else if (s == 0) chain_q[s] <= d_i;
            else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/card_edge_det.sv
`timescale 1ns/1ps
module card_edge_det #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] edge_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/card_chg_flags.sv
`timescale 1ns/1ps
module card_chg_flags #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] flags_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_q[i] <= 1'b0;
            else if (set_i[i]) flags_q[i] <= 1'b1;
            else if (clr_i[i]) flags_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign flags_o = flags_q;

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

   // R3
   clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

   // R1
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/card_stat_irq.sv
`timescale 1ns/1ps
module card_stat_irq
   import card_stat_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_HOST    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cd_pin,
   input  logic [1:0]        bvd_pin,
   input  logic              rdy_pin,
   input  logic              wp_pin,
   input  logic              wait_pin,
   input  logic              pwr_good,
   input  logic              card_irq,
   input  logic              acc_timeout,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic [NUM_HOST-1:0] host_irq_n
);
   generate
      if (NUM_HOST != 2) begin : g_bad_host
         $error("card_stat_irq routes to exactly two host lines");
      end
   endgenerate

   // synchronized raw vector: 0 cd1,1 cd2,2 bvd1,3 bvd2,4 rdy,5 wp,6 wait,7 pwr,8 irq
   logic [NUM_RAW-1:0] raw_s;
   card_sync #(.W(NUM_RAW), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({card_irq, pwr_good, wait_pin, wp_pin, rdy_pin, bvd_pin[1], bvd_pin[0], cd_pin[1], cd_pin[0]}),
      .q_o   (raw_s)
   );

   // control and diagnostic registers
   logic               mode_io_q, io_route_q, io_en_q, sc_route_q;
   logic [NUM_CHG-1:0] chg_en_q;
   logic               diag_en_q;
   logic [NUM_DG-1:0]  diag_val_q;   // cd1, bvd2, bvd1, rdy, wp, wait

   wire wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
   wire wr_diag = reg_wr && (reg_sel_e'(reg_sel) == SEL_DIAG);
   wire wr_stat = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_io_q  <= 1'b0;
         io_route_q <= 1'b0;
         io_en_q    <= 1'b0;
         sc_route_q <= 1'b0;
         chg_en_q   <= '0;
      end else if (wr_ctrl) begin
         mode_io_q  <= reg_wdata[0];
         io_route_q <= reg_wdata[3];
         io_en_q    <= reg_wdata[4];
         chg_en_q   <= reg_wdata[EN_LSB +: NUM_CHG];
         sc_route_q <= reg_wdata[12];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_en_q  <= 1'b0;
         diag_val_q <= '0;
      end else if (wr_diag) begin
         diag_en_q  <= reg_wdata[8];
         diag_val_q <= reg_wdata[DG_LSB +: NUM_DG];
      end
   end

   // effective levels after optional override
   logic eff_cd1, eff_bvd2, eff_bvd1, eff_rdy, eff_wp, eff_wait;
   always_comb begin
      eff_cd1  = diag_en_q ? diag_val_q[5] : raw_s[0];
      eff_bvd2 = diag_en_q ? diag_val_q[4] : raw_s[3];
      eff_bvd1 = diag_en_q ? diag_val_q[3] : raw_s[2];
      eff_rdy  = diag_en_q ? diag_val_q[2] : raw_s[4];
      eff_wp   = diag_en_q ? diag_val_q[1] : raw_s[5];
      eff_wait = diag_en_q ? diag_val_q[0] : raw_s[6];
   end

   logic [5:0] lvl_edge;
   card_edge_det #(.W(6)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({raw_s[1], eff_cd1, eff_bvd2, eff_bvd1, eff_rdy, eff_wp}),
      .edge_o (lvl_edge)
   );

   logic [NUM_CHG-1:0] chg_set, chg_clr, chg_flags;
   assign chg_set = {lvl_edge[5] | lvl_edge[4], lvl_edge[3:0], acc_timeout};
   assign chg_clr = wr_stat ? reg_wdata[CHG_LSB +: NUM_CHG] : '0;

   card_chg_flags #(.N(NUM_CHG)) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (chg_set),
      .clr_i   (chg_clr),
      .flags_o (chg_flags)
   );

   logic sc_post, io_post;
   assign sc_post = |(chg_flags & chg_en_q);
   assign io_post = mode_io_q & raw_s[8];

   logic [WORD_W-1:0] ctrl_word, diag_word, stat_word;
   assign ctrl_word = {3'b000, sc_route_q, chg_en_q, 1'b0, io_en_q, io_route_q, 2'b00, mode_io_q};
   assign diag_word = {1'b0, diag_val_q, diag_en_q, 8'h00};
   assign stat_word = {io_post, sc_post, chg_flags,
                       raw_s[1], eff_cd1, eff_bvd2, eff_bvd1, eff_rdy, eff_wp, eff_wait, raw_s[7]};

   always_comb begin
      case (reg_sel_e'(reg_sel))
         SEL_CTRL: reg_rdata = ctrl_word;
         SEL_DIAG: reg_rdata = diag_word;
         SEL_STAT: reg_rdata = stat_word;
         default:  reg_rdata = '0;
      endcase
   end

   generate
      for (genvar k = 0; k < NUM_HOST; k++) begin : g_host
         assign host_irq_n[k] = ~((sc_post && (sc_route_q == 1'(k))) ||
                                  (io_post && io_en_q && (io_route_q == 1'(k))));
      end
   endgenerate

   // R5
   quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flags == '0 && !raw_s[8]) |-> (host_irq_n == 2'b11));

   // R8
   mem_only_b15_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_io_q && reg_sel_e'(reg_sel) == SEL_STAT) |-> !reg_rdata[15]);

   // R10
   diag_cd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_en_q && reg_sel_e'(reg_sel) == SEL_STAT) |-> (reg_rdata[6] == diag_val_q[5]));
endmodule

// File: tb/test_card_stat_irq.sv
`timescale 1ns/1ps
module test_card_stat_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cd = '0, bvd = '0;
   logic        rdy = 0, wp = 0, wt = 0, pwr = 0, cirq = 0, tmo = 0;
   logic [1:0]  sel = 2'd3;
   logic        wr = 0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  irq_n;
   int          n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   card_stat_irq i_card_stat_irq (
      .clk(clk), .rst_n(rst_n), .cd_pin(cd), .bvd_pin(bvd), .rdy_pin(rdy),
      .wp_pin(wp), .wait_pin(wt), .pwr_good(pwr), .card_irq(cirq),
      .acc_timeout(tmo), .reg_sel(sel), .reg_wr(wr), .reg_wdata(wdata),
      .reg_rdata(rdata), .host_irq_n(irq_n)
   );

   typedef struct packed {
      logic [15:0] ctrl;
      logic [6:0]  stim;   // cd2, cd1, bvd2, bvd1, rdy, wp, timeout
      logic [7:0]  hi;     // expected status[15:8]
      logic [1:0]  irqn;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{16'h0800, 7'h20, 8'h60, 2'b10},
      '{16'h1800, 7'h40, 8'h60, 2'b01},
      '{16'h0000, 7'h10, 8'h10, 2'b11},
      '{16'h0400, 7'h10, 8'h50, 2'b10},
      '{16'h1200, 7'h08, 8'h48, 2'b01},
      '{16'h0100, 7'h04, 8'h44, 2'b10},
      '{16'h0080, 7'h02, 8'h42, 2'b10},
      '{16'h1040, 7'h01, 8'h41, 2'b01},
      '{16'h0080, 7'h04, 8'h04, 2'b11},
      '{16'h0FC0, 7'h06, 8'h46, 2'b10}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
      sel = s; wdata = d; wr = 1'b1;
      tick(1);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [15:0] d);
      sel = s;
      #0.5;
      d = rdata;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [6:0] st);
      cd[1] = cd[1] ^ st[6];
      cd[0] = cd[0] ^ st[5];
      bvd[1] = bvd[1] ^ st[4];
      bvd[0] = bvd[0] ^ st[3];
      rdy = rdy ^ st[2];
      wp  = wp ^ st[1];
      if (st[0]) begin
         tmo = 1'b1; tick(1); tmo = 1'b0;
      end
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R11 reset state
      rd_reg(2'd0, v); chk("R11 ctrl reset", v, 16'h0000);
      rd_reg(2'd1, v); chk("R11 diag reset", v, 16'h0000);
      rd_reg(2'd2, v); chk("R11 status reset", v, 16'h0000);
      rd_reg(2'd3, v); chk("R11 unused select", v, 16'h0000);
      chk("R6 lines idle", {14'd0, irq_n}, 16'h0003);

      // R1 R2 R5 R6 table walk
      for (int i = 0; i < 10; i++) begin
         wr_reg(2'd0, VEC[i].ctrl);
         wr_reg(2'd2, 16'h3F00);
         apply(VEC[i].stim);
         tick(4);
         rd_reg(2'd2, v);
         chk($sformatf("R1 R2 R5 row %0d status", i), {8'h00, v[15:8]}, {8'h00, VEC[i].hi});
         chk($sformatf("R6 row %0d lines", i), {14'd0, irq_n}, {14'd0, VEC[i].irqn});
      end

      // R9 live byte
      wr_reg(2'd0, 16'h0000);
      cd = 2'b10; bvd = 2'b01; rdy = 1; wp = 0; wt = 1; pwr = 1;
      tick(4);
      rd_reg(2'd2, v); chk("R9 live mem mode", {8'h00, v[7:0]}, 16'h009B);
      wr_reg(2'd0, 16'h0001);
      rd_reg(2'd2, v); chk("R9 live io mode", {8'h00, v[7:0]}, 16'h009B);
      wr_reg(2'd0, 16'h0000);

      // R3 write-one-to-clear
      wr_reg(2'd2, 16'h3F00);
      apply(7'h06);
      tick(4);
      wr_reg(2'd2, 16'h0000);
      rd_reg(2'd2, v); chk("R3 write zero keeps", {8'h00, v[15:8]}, 16'h0006);
      wr_reg(2'd2, 16'h0400);
      rd_reg(2'd2, v); chk("R3 clear one bit", {8'h00, v[15:8]}, 16'h0002);

      // R4 set beats clear
      wr_reg(2'd2, 16'h3F00);
      tmo = 1'b1; sel = 2'd2; wdata = 16'h0100; wr = 1'b1;
      tick(1);
      tmo = 1'b0; wr = 1'b0;
      rd_reg(2'd2, v); chk("R4 set wins", {15'd0, v[8]}, 16'h0001);
      wr_reg(2'd2, 16'h0100);
      rd_reg(2'd2, v); chk("R3 timeout cleared", {15'd0, v[8]}, 16'h0000);

      // R10 diagnostic override (cd1 pin is 0 here)
      wr_reg(2'd1, 16'h4100);
      tick(2);
      wr_reg(2'd2, 16'h3F00);
      rd_reg(2'd2, v); chk("R10 override live", {8'h00, v[7:0]}, 16'h00C1);
      cd[0] = 1'b1; rdy = 1'b0;
      tick(4);
      rd_reg(2'd2, v); chk("R10 pin ignored", v, 16'h00C1);
      wr_reg(2'd1, 16'h4500);
      tick(1);
      rd_reg(2'd2, v); chk("R10 diag wp edge", v, 16'h02C5);
      rd_reg(2'd1, v); chk("R11 diag readback", v, 16'h4500);
      wr_reg(2'd1, 16'h0000);
      tick(2);
      wr_reg(2'd2, 16'h3F00);

      // R7 R8 card I/O interrupt
      wr_reg(2'd0, 16'h0019);
      cirq = 1'b1;
      tick(4);
      rd_reg(2'd2, v); chk("R8 io mode bit15", {15'd0, v[15]}, 16'h0001);
      chk("R7 io route line1", {14'd0, irq_n}, 16'h0001);
      wr_reg(2'd0, 16'h0011);
      chk("R7 io route line0", {14'd0, irq_n}, 16'h0002);
      wr_reg(2'd0, 16'h0001);
      rd_reg(2'd2, v); chk("R8 bit15 without enable", {15'd0, v[15]}, 16'h0001);
      chk("R7 io disabled", {14'd0, irq_n}, 16'h0003);
      wr_reg(2'd0, 16'h0018);
      rd_reg(2'd2, v); chk("R8 mem mode bit15", {15'd0, v[15]}, 16'h0000);
      chk("R7 mem mode no io", {14'd0, irq_n}, 16'h0003);

      // R11 unused control bits read zero
      wr_reg(2'd0, 16'hFFFF);
      rd_reg(2'd0, v); chk("R11 ctrl mask", v, 16'h1FD9);
      wr_reg(2'd1, 16'hFFFF);
      rd_reg(2'd1, v); chk("R11 diag mask", v, 16'h7F00);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule